// File: doc/BRIEF.md
# Highway and Farm Road Junction Light Controller

This block runs the signal lights where a busy highway meets a farm road that sees little traffic. The highway keeps a green light until a car waits on the farm road. Then the controller steps the highway through yellow to red and gives the farm road a green light. The farm road keeps that green only while cars keep arriving, up to a fixed maximum. After that the farm road steps through yellow, and the highway becomes green again.

All phase timing comes from an interval counter inside the block. The controller clears this counter on every phase change. The counter raises a short-expired flag after `SHORT_CYCLES` clocks and a long-expired flag after `LONG_CYCLES` clocks. Each flag stays high until the next restart. The short interval sets the length of each yellow. The long interval sets both the shortest highway green and the longest farm green. Each light is driven as a 2-bit colour code from a register. A pulse is also driven out, marking the first cycle of every new phase.

Top module: `tlc_junction_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the highway light is green (00), the farm light is red (10) and `timer_start` is low. Reset also clears the interval counter.
- R2: Each light shows only green = 00, yellow = 01 or red = 10, never 11. At least one of the two lights is red in every cycle.
- R3: While `farm_car` stays low, the highway light stays green for any length of time.
- R4: A highway green lasts at least `LONG_CYCLES`+1 cycles, counted from its first cycle. A car seen only before that point does not end the green.
- R5: Highway yellow lasts exactly `SHORT_CYCLES`+1 cycles. The farm green follows it.
- R6: During farm green, the first clock edge that samples `farm_car` low ends the green. Farm yellow is shown from the next cycle.
- R7: While a farm car stays present, farm green lasts exactly `LONG_CYCLES`+1 cycles.
- R8: Farm yellow lasts exactly `SHORT_CYCLES`+1 cycles. Highway green follows it, and that green again receives its full minimum from R4.
- R9: `timer_start` is high in the first cycle of each new phase and low in every other cycle.
- R10: If a car arrives after the highway minimum has passed, the clock edge that first samples it starts the highway yellow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| farm_car | input | 1 | High while a car waits on the farm road |
| hwy_light | output | 2 | Highway colour code (00 green, 01 yellow, 10 red) |
| farm_light | output | 2 | Farm-road colour code (00 green, 01 yellow, 10 red) |
| timer_start | output | 1 | High in the first cycle of each new phase |

## Verification
The bench measures the length of each phase in cycles. A timer that is off by one, or that is not cleared on a phase change, shows up as a wrong phase length. A stale expired flag would cut a yellow short to a single cycle. A brief car pulse early in the highway green is aimed at a controller that ignores the long interval: that controller would leave green at once. A car dropped partway through the farm green, and a car arriving late in a long highway green, test the cases where the exit must come on the first edge that samples the car input. A design that waits for a timer flag there would hold the green too long.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

  typedef enum logic [1:0] {
    PH_HWY_GO    = 2'd0,
    PH_HWY_WARN  = 2'd1,
    PH_FARM_GO   = 2'd2,
    PH_FARM_WARN = 2'd3
  } phase_t;

  localparam logic [1:0] LAMP_GREEN  = 2'b00;
  localparam logic [1:0] LAMP_YELLOW = 2'b01;
  localparam logic [1:0] LAMP_RED    = 2'b10;

  typedef struct packed {
    logic [1:0] hwy;
    logic [1:0] farm;
  } lamps_t;

  function automatic lamps_t lamps_for(phase_t p);
    lamps_t l;
    case (p)
      PH_HWY_GO:    begin l.hwy = LAMP_GREEN;  l.farm = LAMP_RED;    end
      PH_HWY_WARN:  begin l.hwy = LAMP_YELLOW; l.farm = LAMP_RED;    end
      PH_FARM_GO:   begin l.hwy = LAMP_RED;    l.farm = LAMP_GREEN;  end
      default:      begin l.hwy = LAMP_RED;    l.farm = LAMP_YELLOW; end
    endcase
    return l;
  endfunction

endpackage

// File: rtl/tlc_interval_timer.sv
module tlc_interval_timer #(
  parameter int SHORT_CYCLES = 3,
  parameter int LONG_CYCLES  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic short_done,
  output logic long_done
);
  localparam int CNT_W = $clog2(LONG_CYCLES + 1);
  localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_CYCLES);
  localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_CYCLES);

  logic [CNT_W-1:0] cnt;

  // Saturating counter; cleared by reset or by a phase change.
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (cnt != LONG_V) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign short_done = (cnt >= SHORT_V);
  assign long_done  = (cnt >= LONG_V);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LONG_V);                                                   // R4
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (rst)
    restart |=> !short_done);                                         // R5
  AST_SHORT_FIRST: assert property (@(posedge clk) disable iff (rst)
    long_done |-> short_done);                                        // R7

endmodule

// File: rtl/tlc_phase_fsm.sv
module tlc_phase_fsm
  import tlc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   farm_car,
  input  logic   short_done,
  input  logic   long_done,
  output phase_t phase,
  output phase_t phase_nxt,
  output logic   go
);

  always_comb begin
    phase_nxt = phase;
    go        = 1'b0;
    case (phase)
      PH_HWY_GO:    if (farm_car && long_done)  begin phase_nxt = PH_HWY_WARN;  go = 1'b1; end
      PH_HWY_WARN:  if (short_done)             begin phase_nxt = PH_FARM_GO;   go = 1'b1; end
      PH_FARM_GO:   if (long_done || !farm_car) begin phase_nxt = PH_FARM_WARN; go = 1'b1; end
      default:      if (short_done)             begin phase_nxt = PH_HWY_GO;    go = 1'b1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_HWY_GO;
    else     phase <= phase_nxt;
  end

  AST_HWY_MIN_GREEN: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HWY_GO && !long_done) |=> (phase == PH_HWY_GO));     // R4
  AST_HWY_YELLOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HWY_WARN && !short_done) |=> (phase == PH_HWY_WARN)); // R5
  AST_FARM_DROP_EXIT: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FARM_GO && !farm_car) |=> (phase == PH_FARM_WARN));  // R6
  AST_FARM_MAX_GREEN: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FARM_GO && long_done) |=> (phase == PH_FARM_WARN));  // R7
  AST_NO_CAR_STAY: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HWY_GO && !farm_car) |=> (phase == PH_HWY_GO));      // R3

endmodule

// File: rtl/tlc_lamp_reg.sv
module tlc_lamp_reg
  import tlc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  phase_t     phase_nxt,
  input  logic       go,
  output logic [1:0] hwy_light,
  output logic [1:0] farm_light,
  output logic       start_flag
);
  lamps_t lamps_d;
  assign lamps_d = lamps_for(phase_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      hwy_light  <= LAMP_GREEN;
      farm_light <= LAMP_RED;
      start_flag <= 1'b0;
    end else begin
      hwy_light  <= lamps_d.hwy;
      farm_light <= lamps_d.farm;
      start_flag <= go;
    end
  end

  AST_LEGAL_CODES: assert property (@(posedge clk) disable iff (rst)
    (hwy_light != 2'b11) && (farm_light != 2'b11));                   // R2

endmodule

// File: rtl/tlc_junction_ctrl.sv
module tlc_junction_ctrl
  import tlc_pkg::*;
#(
  parameter int SHORT_CYCLES = 3,
  parameter int LONG_CYCLES  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       farm_car,
  output logic [1:0] hwy_light,
  output logic [1:0] farm_light,
  output logic       timer_start
);
  phase_t phase, phase_nxt;
  logic   go, short_done, long_done;

  tlc_interval_timer #(
    .SHORT_CYCLES (SHORT_CYCLES),
    .LONG_CYCLES  (LONG_CYCLES)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .restart    (go),
    .short_done (short_done),
    .long_done  (long_done)
  );

  tlc_phase_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .farm_car   (farm_car),
    .short_done (short_done),
    .long_done  (long_done),
    .phase      (phase),
    .phase_nxt  (phase_nxt),
    .go         (go)
  );

  tlc_lamp_reg u_lamps (
    .clk        (clk),
    .rst        (rst),
    .phase_nxt  (phase_nxt),
    .go         (go),
    .hwy_light  (hwy_light),
    .farm_light (farm_light),
    .start_flag (timer_start)
  );

  AST_ONE_ROAD_MOVES: assert property (@(posedge clk) disable iff (rst)
    (hwy_light == LAMP_RED) || (farm_light == LAMP_RED));             // R2
  AST_START_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    timer_start == ({hwy_light, farm_light} != $past({hwy_light, farm_light}))); // R9
  AST_LAMPS_TRACK_PHASE: assert property (@(posedge clk) disable iff (rst)
    {hwy_light, farm_light} == lamps_for(phase));                     // R2

endmodule

// File: tb/tlc_junction_ctrl_tb.sv
module tlc_junction_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int S = 3;
  localparam int L = 8;
  localparam logic [1:0] G = 2'b00, Y = 2'b01, RD = 2'b10;

  logic clk = 0, rst = 1, farm_car = 0;
  logic [1:0] hwy_light, farm_light;
  logic timer_start;
  int checks = 0, fails = 0;

  tlc_junction_ctrl #(.SHORT_CYCLES(S), .LONG_CYCLES(L)) u_dut (
    .clk(clk), .rst(rst), .farm_car(farm_car),
    .hwy_light(hwy_light), .farm_light(farm_light), .timer_start(timer_start));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge; counts samples while lights match, checks R2/R9 on the way.
  task automatic count_run(input logic [1:0] h, input logic [1:0] f, output int n);
    int bad = 0;
    n = 0;
    while (hwy_light == h && farm_light == f && n < 1000) begin
      if (n > 0 && timer_start) bad++;
      if (hwy_light != RD && farm_light != RD) bad++;
      n++;
      @(negedge clk);
    end
    chk("R9/R2 mid-phase start low, one road red", bad, 0);
  endtask

  task automatic entry_chk(input string req, input logic [1:0] h, input logic [1:0] f);
    chk(req, {hwy_light, farm_light}, {h, f});
    chk("R9 start high at phase entry", timer_start, 1);
  endtask

  task automatic do_reset(input logic car);
    rst = 1; farm_car = car;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic t_reset;
    rst = 1; farm_car = 0;
    repeat (3) @(negedge clk);
    chk("R1 hwy green in reset", hwy_light, G);
    chk("R1 farm red in reset", farm_light, RD);
    chk("R1 start low in reset", timer_start, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 green after reset", {hwy_light, farm_light}, {G, RD});
    chk("R1 start low after reset", timer_start, 0);
  endtask

  task automatic t_no_car;
    int bad = 0;
    do_reset(0);
    repeat (40) begin
      @(negedge clk);
      if (hwy_light != G || farm_light != RD || timer_start) bad++;
    end
    chk("R3 highway stays green without car", bad, 0);
  endtask

  task automatic t_full_cycle;
    int n;
    do_reset(1);
    count_run(G, RD, n);   chk("R4 hwy green length", n, L + 1);
    entry_chk("R5 hwy yellow entered", Y, RD);
    count_run(Y, RD, n);   chk("R5 hwy yellow length", n, S + 1);
    entry_chk("R7 farm green entered", RD, G);
    count_run(RD, G, n);   chk("R7 farm green capped", n, L + 1);
    entry_chk("R8 farm yellow entered", RD, Y);
    count_run(RD, Y, n);   chk("R8 farm yellow length", n, S + 1);
    entry_chk("R8 hwy green again", G, RD);
    count_run(G, RD, n);   chk("R8 full hwy minimum again", n, L + 1);
  endtask

  task automatic t_early_pulse;
    int bad = 0;
    do_reset(1);
    repeat (3) @(negedge clk);
    farm_car = 0;
    repeat (30) begin
      @(negedge clk);
      if (hwy_light != G) bad++;
    end
    chk("R4 early car pulse ignored", bad, 0);
  endtask

  task automatic t_car_drop_and_late;
    int n;
    do_reset(1);
    count_run(G, RD, n);
    count_run(Y, RD, n);
    chk("R6 farm green reached", farm_light, G);
    @(negedge clk);
    farm_car = 0;
    @(negedge clk);
    chk("R6 farm yellow after car drop", {hwy_light, farm_light}, {RD, Y});
    count_run(RD, Y, n);
    repeat (20) @(negedge clk);
    chk("R3 green held after return", hwy_light, G);
    farm_car = 1;
    @(negedge clk);
    entry_chk("R10 late car starts yellow at once", Y, RD);
    farm_car = 0;
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_no_car();
    t_full_cycle();
    t_early_pulse();
    t_car_drop_and_late();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule